// File: doc/BRIEF.md
# Receive IPv4 Checksum Verifier

This block sits beside the receive path of an Ethernet MAC. It watches the frame byte stream (start, valid and end markers with one byte per valid cycle) and works out whether the frame's IPv4 header checksum, and the TCP or UDP checksum behind it, can be checked and are correct. The parse follows the Ethernet addresses, at most one 802.1Q tag, then either a plain EtherType or an 802.2 LLC/SNAP header. It goes on through the IPv4 header and into the transport segment. The transport sum also covers the pseudo-header built from the IPv4 source and destination, the protocol and the transport length.

The parser is one state machine. Its states are `PS_IDLE` (between frames), `PS_ADDR` (12 address bytes), `PS_ETYPE` (type or length field), `PS_VTAG` (tag control word), `PS_LLC` (8 LLC/SNAP bytes), `PS_IPHDR` (IPv4 header), `PS_XPORT` (transport bytes) and `PS_SKIP` (frame not eligible, wait for its end). The transitions are:
- A start byte restarts the machine in `PS_ADDR`.
- `PS_ADDR` goes to `PS_ETYPE` after 12 bytes.
- `PS_ETYPE` goes to `PS_VTAG` on the first tag type, to `PS_IPHDR` on type 0x0800, to `PS_LLC` on a length value, and otherwise to `PS_SKIP`.
- `PS_VTAG` returns to `PS_ETYPE`, or goes to `PS_SKIP` when the CFI bit is set.
- `PS_LLC` goes to `PS_IPHDR` on a full match and to `PS_SKIP` on the first mismatch.
- `PS_IPHDR` goes to `PS_XPORT` when the transport segment is eligible, and otherwise to `PS_SKIP`.
- Every end byte returns the machine to `PS_IDLE`.

One cycle after the end byte the block presents a status strobe with descriptor flags and a discard request. A saturating counter counts the frames discarded. When checking is off, the flags carry the upstream type-ID match result instead.

Top module: `ipck_rx_offload`

## Requirements
- R1: `st_vld` is high for exactly one cycle, the cycle after the cycle in which a byte with `rx_eof` is accepted. It stays low at all other times, including valid gaps in the frame.
- R2: The IPv4 header words are summed alone, and a result of 0xFFFF means the header is good. A good header whose transport is not checked gives code 2'b01 in `st_flags[1:0]`. A bad header gives code 2'b00 and `st_drop`=1.
- R3: For protocol 6 (TCP), the sum over the pseudo-header and the whole segment gives code 2'b10 when correct. When it is wrong the block gives code 2'b00 and `st_drop`=1.
- R4: For protocol 17 (UDP), a correct sum gives code 2'b11. A UDP checksum field (segment bytes 6 and 7) of 0x0000 gives code 2'b01 with no drop.
- R5: Only the bytes within the IPv4 total length are summed, so trailing pad bytes have no effect. An odd last byte is summed as the high byte of a word whose low byte is zero.
- R6: One tag (type 0x8100 followed by a tag control word whose bit 12, CFI, is 0) is skipped and checking goes on. A set CFI bit, or a second tag, gives code 2'b00 and no drop, whatever the checksums.
- R7: A type/length value of 1500 or less, followed by the bytes AA AA 03 00 00 00 08 00, is accepted as SNAP and sets `st_flags[2]`. Any other bytes give code 2'b00, `st_flags[2]`=0 and no drop.
- R8: Nothing is verified, and nothing dropped, unless the version is 4, IHL is at least 5, the total length is at least IHL×4 and the frame holds the whole header. If the frame ends inside the transport segment, the transport is not verified.
- R9: A fragmented packet (MF flag or a non-zero fragment offset) has only its header checked. A wrong transport sum then gives code 2'b01 and no drop.
- R10: When `chk_en` is 0 at the end byte, `st_flags` is {0, `tid_hit`} as sampled at the end byte, and `st_drop` is 0.
- R11: `drop_cnt` goes up by one for each strobe with `st_drop`=1, one cycle after the strobe. It holds at its all-ones maximum. A `cnt_clr` cycle zeroes it next cycle and takes priority over a drop.
- R12: After reset, `st_vld`, `st_flags`, `st_drop` and `drop_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Checksum checking enable, sampled with the end byte |
| tid_hit | input | 2 | Type-ID match flags from the address filter, sampled with the end byte |
| cnt_clr | input | 1 | Synchronous clear of the discard counter |
| rx_sof | input | 1 | First byte of a frame |
| rx_vld | input | 1 | Byte valid |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| st_vld | output | 1 | Status strobe |
| st_flags | output | 3 | [2] SNAP, [1:0] checksum code (or type-ID flags when disabled) |
| st_drop | output | 1 | Discard request |
| drop_cnt | output | CNT_W (32) | Saturating count of discarded frames |

## Verification
Three results are due at fixed times, counted from the clock edge that accepts the end byte. The status strobe, flags and discard request are registered at that edge. The bench therefore reads them at the falling edge that follows, and again one cycle later to confirm the strobe has dropped. The counter takes one more register stage, so the bench reads it one cycle after the strobe. A clear is read at the falling edge after the edge that accepts it. During streaming, the bench also samples the strobe at every falling edge, including idle gaps, to confirm no early status.

// File: rtl/ipck_pkg.sv
`timescale 1ns/1ps
package ipck_pkg;

    localparam int          ADDR_BYTES = 12;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    localparam logic [1:0] CS_NONE = 2'b00;
    localparam logic [1:0] CS_IP   = 2'b01;
    localparam logic [1:0] CS_TCP  = 2'b10;
    localparam logic [1:0] CS_UDP  = 2'b11;

    typedef enum logic [2:0] {
        PS_IDLE, PS_ADDR, PS_ETYPE, PS_VTAG, PS_LLC, PS_IPHDR, PS_XPORT, PS_SKIP
    } pstate_e;

    typedef struct packed {
        pstate_e     st;
        logic [15:0] pos;
        logic [7:0]  hi;
        logic        vtag;
        logic        snap;
        logic [3:0]  ihl;
        logic [15:0] tlen;
        logic [7:0]  proto;
        logic        frag;
        logic [15:0] ipsum;
        logic [15:0] ps;
        logic [15:0] l4sum;
        logic [15:0] xlen;
        logic        hdr_done;
        logic        ip_good;
        logic        in_xp;
        logic        udpz;
    } ctx_t;

    // one's-complement add with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    // expected LLC/SNAP byte at a given position
    function automatic logic [7:0] snap_byte(input logic [2:0] i);
        unique case (i)
            3'd0, 3'd1: return 8'hAA;
            3'd2:       return 8'h03;
            3'd6:       return 8'h08;
            default:    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ipck_parse.sv
`timescale 1ns/1ps
module ipck_parse
    import ipck_pkg::*;
#(
    parameter logic [15:0] TPID    = 16'h8100,
    parameter logic [15:0] MAX_LEN = 16'd1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       vld,
    input  logic       eof,
    input  logic [7:0] d,
    output logic       res_vld,
    output logic [1:0] res_code,
    output logic       res_snap,
    output logic       res_bad
);

    ctx_t        ctx_q, c;
    logic        fin_q;
    pstate_e     st;
    logic [15:0] p, word, hbytes;
    logic        xp_done, l4_chk, l4_good;
    logic [15:0] tail;

    // next-state and datapath
    always_comb begin
        c      = ctx_q;
        st     = ctx_q.st;
        p      = ctx_q.pos;
        if (vld && sof) begin
            c  = '0;
            st = PS_ADDR;
            p  = 16'd0;
        end
        word   = {c.hi, d};
        hbytes = {10'd0, c.ihl, 2'b00};
        if (vld) begin
            c.st  = st;
            c.pos = (p == 16'hFFFF) ? p : p + 16'd1;
            unique case (st)
                PS_IDLE, PS_SKIP: ;
                PS_ADDR: begin
                    if (p == 16'(ADDR_BYTES - 1)) begin
                        c.st  = PS_ETYPE;
                        c.pos = 16'd0;
                    end
                end
                PS_ETYPE: begin
                    if (!p[0]) c.hi = d;
                    else begin
                        c.pos = 16'd0;
                        if (word == TPID && !c.vtag)  c.st = PS_VTAG;
                        else if (word == ETYPE_IPV4)  c.st = PS_IPHDR;
                        else if (word <= MAX_LEN)     c.st = PS_LLC;
                        else                          c.st = PS_SKIP;
                    end
                end
                PS_VTAG: begin
                    if (!p[0]) begin
                        if (d[4]) c.st = PS_SKIP;
                    end else begin
                        c.st   = PS_ETYPE;
                        c.pos  = 16'd0;
                        c.vtag = 1'b1;
                    end
                end
                PS_LLC: begin
                    if (d != snap_byte(p[2:0])) c.st = PS_SKIP;
                    else if (p == 16'd7) begin
                        c.st   = PS_IPHDR;
                        c.pos  = 16'd0;
                        c.snap = 1'b1;
                    end
                end
                PS_IPHDR: begin
                    if (!p[0]) c.hi = d;
                    else       c.ipsum = oc_add(c.ipsum, word);
                    if (p == 16'd0) begin
                        c.ihl = d[3:0];
                        if (d[7:4] != 4'd4 || d[3:0] < 4'd5) c.st = PS_SKIP;
                    end
                    if (p == 16'd3) c.tlen  = word;
                    if (p == 16'd7) c.frag  = c.hi[5] | ({c.hi[4:0], d} != 13'd0);
                    if (p == 16'd9) c.proto = d;
                    if (p >= 16'd12 && p <= 16'd19 && p[0]) c.ps = oc_add(c.ps, word);
                    if (c.st == PS_IPHDR && p >= 16'd19 && p == hbytes - 16'd1) begin
                        c.pos = 16'd0;
                        if (c.tlen < hbytes) c.st = PS_SKIP;
                        else begin
                            c.hdr_done = 1'b1;
                            c.ip_good  = (c.ipsum == 16'hFFFF);
                            c.xlen     = c.tlen - hbytes;
                            c.ps       = oc_add(oc_add(c.ps, {8'h00, c.proto}), c.xlen);
                            c.in_xp    = c.ip_good && !c.frag &&
                                         (c.proto == PROTO_TCP || c.proto == PROTO_UDP);
                            c.st       = c.in_xp ? PS_XPORT : PS_SKIP;
                        end
                    end
                end
                PS_XPORT: begin
                    if (p < c.xlen) begin
                        if (!p[0]) c.hi = d;
                        else       c.l4sum = oc_add(c.l4sum, word);
                        if (p == 16'd7 && c.proto == PROTO_UDP) c.udpz = (word == 16'd0);
                    end
                end
            endcase
            if (eof) c.st = PS_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
            fin_q <= 1'b0;
        end else begin
            ctx_q <= c;
            fin_q <= vld && eof;
        end
    end

    // outputs
    always_comb begin
        xp_done  = ctx_q.in_xp && (ctx_q.pos >= ctx_q.xlen);
        tail     = ctx_q.xlen[0] ? oc_add(ctx_q.l4sum, {ctx_q.hi, 8'h00}) : ctx_q.l4sum;
        l4_good  = (oc_add(tail, ctx_q.ps) == 16'hFFFF);
        l4_chk   = xp_done && !(ctx_q.proto == PROTO_UDP && ctx_q.udpz);
        res_vld  = fin_q;
        res_snap = fin_q && ctx_q.snap;
        res_bad  = fin_q && ctx_q.hdr_done && (!ctx_q.ip_good || (l4_chk && !l4_good));
        if (!fin_q || !ctx_q.hdr_done || !ctx_q.ip_good) res_code = CS_NONE;
        else if (!l4_chk)                                 res_code = CS_IP;
        else if (!l4_good)                                res_code = CS_NONE;
        else res_code = (ctx_q.proto == PROTO_TCP) ? CS_TCP : CS_UDP;
    end

    a_r1_status_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && eof) |=> res_vld);
    a_r1_status_only_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(vld && eof));
    a_r2_bad_not_verified: assert property (@(posedge clk) disable iff (!rst_n)
        res_bad |-> (res_code == CS_NONE));

endmodule

// File: rtl/ipck_dropcnt.sv
`timescale 1ns/1ps
module ipck_dropcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (inc && cnt != MAXV)  cnt <= cnt + ONE;
    end

    a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV));
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != MAXV) |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/ipck_rx_offload.sv
`timescale 1ns/1ps
module ipck_rx_offload
    import ipck_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter logic [15:0] TPID    = 16'h8100,
    parameter logic [15:0] MAX_LEN = 16'd1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [1:0]       tid_hit,
    input  logic             cnt_clr,
    input  logic             rx_sof,
    input  logic             rx_vld,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    output logic             st_vld,
    output logic [2:0]       st_flags,
    output logic             st_drop,
    output logic [CNT_W-1:0] drop_cnt
);

    logic       res_vld, res_snap, res_bad;
    logic [1:0] res_code;
    logic       en_q;
    logic [1:0] tid_q;

    ipck_parse #(.TPID(TPID), .MAX_LEN(MAX_LEN)) u_parse (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .vld(rx_vld), .eof(rx_eof),
        .d(rx_data), .res_vld(res_vld), .res_code(res_code),
        .res_snap(res_snap), .res_bad(res_bad)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            tid_q <= 2'b00;
        end else if (rx_vld && rx_eof) begin
            en_q  <= chk_en;
            tid_q <= tid_hit;
        end
    end

    always_comb begin
        st_vld = res_vld;
        if (!res_vld)  st_flags = 3'b000;
        else if (en_q) st_flags = {res_snap, res_code};
        else           st_flags = {1'b0, tid_q};
        st_drop = en_q && res_bad;
    end

    ipck_dropcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(st_drop), .cnt(drop_cnt)
    );

    a_r10_no_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_eof && !chk_en) |=> !st_drop);
    a_r1_flags_only_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !st_vld |-> (st_flags == 3'b000 && !st_drop));

endmodule

// File: tb/ipck_rx_offload_test.sv
`timescale 1ns/1ps
module ipck_rx_offload_test;

    localparam int TB_CW = 4;
    localparam int MAXC  = (1 << TB_CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic chk_en = 1'b1, cnt_clr = 1'b0;
    logic [1:0] tid_hit = 2'b00;
    logic rx_sof = 0, rx_vld = 0, rx_eof = 0;
    logic [7:0] rx_data = 8'h00;
    logic st_vld, st_drop;
    logic [2:0] st_flags;
    logic [TB_CW-1:0] drop_cnt;

    always #2 clk = ~clk;

    ipck_rx_offload #(.CNT_W(TB_CW)) uut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .tid_hit(tid_hit), .cnt_clr(cnt_clr),
        .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_eof(rx_eof), .rx_data(rx_data),
        .st_vld(st_vld), .st_flags(st_flags), .st_drop(st_drop), .drop_cnt(drop_cnt)
    );

    int n_chk = 0, n_fail = 0, exp_cnt = 0, early = 0;
    logic [7:0] fb [0:511];
    int wi, flen;
    int c_vlan, c_snap, c_ihl, c_ver, c_plen, c_pad, c_trunc, c_tl_ov, c_gap;
    logic [7:0] c_proto;
    bit c_frag, c_bad_ip, c_bad_l4, c_udp0, c_clr;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input logic [31:0] s);
        logic [31:0] t = s;
        while (t[31:16] != 0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
        return t[15:0];
    endfunction

    task automatic defaults();
        c_vlan = 0; c_snap = 0; c_ihl = 5; c_ver = 4; c_plen = 40; c_pad = 0;
        c_trunc = 0; c_tl_ov = -1; c_gap = 0; c_proto = 8'd6;
        c_frag = 0; c_bad_ip = 0; c_bad_l4 = 0; c_udp0 = 0; c_clr = 0;
        chk_en = 1'b1; tid_hit = 2'b00;
    endtask

    task automatic put(input logic [7:0] b);
        fb[wi] = b;
        wi++;
    endtask

    task automatic build();
        int h, t, tl, cso;
        logic [31:0] s;
        logic [15:0] cs;
        wi = 0;
        for (int k = 0; k < 12; k++) put(8'(8'h02 + k));
        if (c_vlan >= 1) begin
            put(8'h81); put(8'h00); put(c_vlan == 2 ? 8'h10 : 8'h00); put(8'h05);
        end
        if (c_vlan == 3) begin put(8'h81); put(8'h00); put(8'h00); put(8'h06); end
        if (c_snap == 0) begin put(8'h08); put(8'h00); end
        else begin
            put(8'h00); put(8'h40); put(8'hAA); put(8'hAA); put(8'h03);
            put(8'h00); put(8'h00); put(8'h00);
            put(c_snap == 1 ? 8'h08 : 8'h86); put(c_snap == 1 ? 8'h00 : 8'hDD);
        end
        h  = wi;
        tl = (c_tl_ov >= 0) ? c_tl_ov : c_ihl * 4 + c_plen;
        put({c_ver[3:0], c_ihl[3:0]}); put(8'h00); put(tl[15:8]); put(tl[7:0]);
        put(8'h12); put(8'h34); put(c_frag ? 8'h20 : 8'h00); put(8'h00);
        put(8'h40); put(c_proto); put(8'h00); put(8'h00);
        put(8'h0a); put(8'h00); put(8'h00); put(8'h01);
        put(8'hc0); put(8'ha8); put(8'h01); put(8'h07);
        for (int k = 0; k < (c_ihl - 5) * 4; k++) put(8'h01);
        s = 0;
        for (int k = 0; k < c_ihl * 4; k += 2) s += {16'd0, fb[h+k], fb[h+k+1]};
        cs = ~fold(s);
        fb[h+10] = cs[15:8];
        fb[h+11] = cs[7:0] ^ (c_bad_ip ? 8'h01 : 8'h00);
        t = wi;
        for (int k = 0; k < c_plen; k++) put(8'(k * 7 + 3));
        cso = (c_proto == 8'd6) ? 16 : (c_proto == 8'd17) ? 6 : -1;
        if (c_proto == 8'd17) begin fb[t+4] = 8'(c_plen >> 8); fb[t+5] = 8'(c_plen); end
        if (cso >= 0) begin
            fb[t+cso] = 8'h00; fb[t+cso+1] = 8'h00;
            s = 32'h0a00 + 32'h0001 + 32'hc0a8 + 32'h0107 + {24'd0, c_proto} + c_plen;
            for (int k = 0; k < c_plen; k += 2)
                s += {16'd0, fb[t+k], (k + 1 < c_plen) ? fb[t+k+1] : 8'h00};
            cs = ~fold(s);
            if (c_proto == 8'd17 && cs == 16'h0000) cs = 16'hFFFF;
            if (c_udp0) cs = 16'h0000;
            fb[t+cso] = cs[15:8]; fb[t+cso+1] = cs[7:0];
        end
        if (c_bad_l4) fb[t+c_plen-1] = fb[t+c_plen-1] ^ 8'h04;
        for (int k = 0; k < c_pad; k++) put(8'h55);
        flen = wi - c_trunc;
    endtask

    task automatic send();
        early = 0;
        for (int k = 0; k < flen; k++) begin
            if (c_gap > 0 && k > 0 && (k % c_gap) == 0) begin
                @(negedge clk);
                if (st_vld) early++;
                rx_vld = 0; rx_sof = 0; rx_eof = 0;
            end
            @(negedge clk);
            if (st_vld) early++;
            rx_vld = 1; rx_sof = (k == 0); rx_eof = (k == flen - 1); rx_data = fb[k];
        end
        @(negedge clk);
        rx_vld = 0; rx_sof = 0; rx_eof = 0;
    endtask

    // send one frame, check status in the cycle after the end byte, counter one later
    task automatic run(input string req, input logic [2:0] ef, input bit ed);
        build();
        send();
        check(req, "strobe", {31'd0, st_vld}, 1);
        check(req, "flags", {29'd0, st_flags}, {29'd0, ef});
        check(req, "drop", {31'd0, st_drop}, {31'd0, ed});
        if (c_clr) begin cnt_clr = 1; exp_cnt = 0; end
        else if (ed && exp_cnt < MAXC) exp_cnt++;
        @(negedge clk);
        cnt_clr = 0;
        check("R1", "strobe one cycle", {31'd0, st_vld}, 0);
        check("R1", "no early strobe", early, 0);
        check("R11", "drop count", {28'd0, drop_cnt}, exp_cnt);
    endtask

    task automatic t_reset();
        check("R12", "reset strobe", {31'd0, st_vld}, 0);
        check("R12", "reset flags", {29'd0, st_flags}, 0);
        check("R12", "reset drop", {31'd0, st_drop}, 0);
        check("R12", "reset count", {28'd0, drop_cnt}, 0);
    endtask

    task automatic t_tcp();
        defaults(); run("R3 tcp good", 3'b010, 0);
        defaults(); c_gap = 3; c_plen = 33; run("R1 gaps", 3'b010, 0);
        defaults(); c_bad_l4 = 1; run("R3 tcp bad", 3'b000, 1);
    endtask

    task automatic t_udp();
        defaults(); c_proto = 8'd17; c_plen = 27; run("R5 udp odd", 3'b011, 0);
        defaults(); c_proto = 8'd17; c_udp0 = 1; run("R4 udp zero", 3'b001, 0);
        defaults(); c_proto = 8'd17; c_bad_l4 = 1; run("R4 udp bad", 3'b000, 1);
    endtask

    task automatic t_header();
        defaults(); c_proto = 8'd1; c_plen = 12; run("R2 other proto", 3'b001, 0);
        defaults(); c_bad_ip = 1; run("R2 bad header", 3'b000, 1);
    endtask

    task automatic t_pad();
        defaults(); c_proto = 8'd17; c_plen = 30; c_pad = 14; run("R5 padding", 3'b011, 0);
        defaults(); c_ihl = 6; c_pad = 6; run("R8 options", 3'b010, 0);
    endtask

    task automatic t_vlan();
        defaults(); c_vlan = 1; run("R6 one tag", 3'b010, 0);
        defaults(); c_vlan = 2; c_bad_ip = 1; run("R6 cfi set", 3'b000, 0);
        defaults(); c_vlan = 3; c_bad_ip = 1; run("R6 two tags", 3'b000, 0);
    endtask

    task automatic t_snap();
        defaults(); c_snap = 1; c_proto = 8'd17; run("R7 snap", 3'b111, 0);
        defaults(); c_snap = 2; c_bad_ip = 1; run("R7 other llc", 3'b000, 0);
    endtask

    task automatic t_frag();
        defaults(); c_frag = 1; c_bad_l4 = 1; run("R9 fragment", 3'b001, 0);
    endtask

    task automatic t_elig();
        defaults(); c_ver = 6; c_bad_ip = 1; run("R8 version", 3'b000, 0);
        defaults(); c_tl_ov = 16; run("R8 short total", 3'b000, 0);
        defaults(); c_trunc = c_plen + 10; run("R8 cut header", 3'b000, 0);
        defaults(); c_trunc = 5; run("R8 cut transport", 3'b001, 0);
    endtask

    task automatic t_off();
        defaults(); chk_en = 0; tid_hit = 2'b10; c_bad_ip = 1;
        run("R10 disabled", 3'b010, 0);
    endtask

    task automatic t_count();
        for (int k = 0; k < MAXC + 2; k++) begin
            defaults(); c_bad_ip = 1; run("R11 saturate", 3'b000, 1);
        end
        check("R11", "saturated", {28'd0, drop_cnt}, MAXC);
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0; exp_cnt = 0;
        check("R11", "clear", {28'd0, drop_cnt}, 0);
        defaults(); c_bad_ip = 1; run("R11 count after clear", 3'b000, 1);
        defaults(); c_bad_ip = 1; c_clr = 1; run("R11 clear priority", 3'b000, 1);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_tcp();
        t_udp();
        t_header();
        t_pad();
        t_vlan();
        t_snap();
        t_frag();
        t_elig();
        t_off();
        t_count();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule